// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block sits between a CAN protocol controller and the bus driver of a transceiver. It watches the transmit data line coming from the controller, where low means dominant and high means recessive. It passes that line to the driver only for as long as a dominant stretch stays within a configured limit. If the controller holds the line dominant past that limit, the block forces the driver to recessive and raises a fault flag. The bus is then free for the other nodes.

The transmit input is brought into the clock domain through a synchronizer whose flops reset to the recessive level, so a line that has not yet been driven counts as recessive. A timer measures each continuous dominant stretch of the synchronized line. It starts from zero at every high-to-low transition. Once tripped, the guard stays tripped for as long as the input stays low. Only a return of the input to recessive clears it. A mode input selects active operation; while it is low (standby) the driver output is recessive, the timer is cleared and the fault is cleared.

The limit `TIMEOUT_CYC` is given in clock cycles. At 200 MHz the 2 ms default is 400000 cycles. An integrator should keep it between 300 µs and 6 ms of clock time. The lower bound keeps eleven consecutive dominant bits at 40 kbit/s inside the window.

Top module: `txd_stuck_guard`

## Requirements
- R1: While reset is asserted, and at its release, `drv_txd` is 1 and `fault` is 0, whatever level `txd_in` has.
- R2: In active mode (`active_en` = 1) with no fault, `drv_txd` equals `txd_in` delayed by two clock edges. A sample taken after edge n shows the value that was present before edge n-1.
- R3: Let a dominant stretch be the number of consecutive samples at which the synchronized input is low. A stretch of `TIMEOUT_CYC` samples sets `fault` at the edge after the last of them, and from then on forces `drv_txd` to 1. A stretch of `TIMEOUT_CYC`-1 samples never sets `fault`.
- R4: Once set in active mode, `fault` stays 1 and `drv_txd` stays 1 for as long as `txd_in` stays low, with no limit on the duration.
- R5: After a trip, `fault` returns to 0 three clock edges after `txd_in` is driven high. The next dominant stretch then gets a full `TIMEOUT_CYC` window again.
- R6: While `active_en` is 0, `drv_txd` is 1 in the same cycle, and `fault` and the timer are 0 from the next edge onward. When `active_en` returns to 1 with the synchronized input low, timing starts from zero, and `fault` is set at the `TIMEOUT_CYC`-th edge.
- R7: A single recessive sample between two dominant stretches restarts the timer. Two stretches of `TIMEOUT_CYC`-1 samples separated by one high sample never set `fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| txd_in | input | 1 | Transmit data from the protocol controller, 0 = dominant |
| active_en | input | 1 | 1 = active mode, 0 = standby |
| drv_txd | output | 1 | Gated transmit data to the bus driver, 1 = recessive |
| fault | output | 1 | Dominant timeout has tripped |

## Verification
`drv_txd` follows `txd_in` after two edges. A trip becomes visible at edge `TIMEOUT_CYC`+2 after the input falls, and it clears at the third edge after the input rises. The bench counts the edges from each stimulus and derives the expected level for every sample from those offsets. It drives inputs and samples outputs at the falling clock edge, so each check sees the state settled after a known number of rising edges. A sweep of dominant lengths from one cycle to a few cycles past the limit checks both sides of the trip boundary. The sweep also checks the release timing at every length.

// File: rtl/tdg_pkg.sv
package tdg_pkg;
  typedef enum logic {
    GUARD_OK   = 1'b0,
    GUARD_TRIP = 1'b1
  } guard_st_e;
endpackage

// File: rtl/tdg_sync.sv
module tdg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out,
  output logic rise
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;
  logic              last_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    if (i == 0) begin : g_first
      assign stg_d[i] = async_in;
    end else begin : g_next
      assign stg_d[i] = stg_q[i-1];
    end
  end

  // stages reset recessive so an undriven line reads high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= '1;
      last_q <= 1'b1;
    end else begin
      stg_q  <= stg_d;
      last_q <= stg_q[STAGES-1];
    end
  end

  assign sync_out = stg_q[STAGES-1];
  assign rise     = sync_out & ~last_q;
endmodule

// File: rtl/tdg_timer.sv
module tdg_timer
  import tdg_pkg::*;
#(
  parameter int TIMEOUT_CYC = 400000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic dom,
  input  logic rise,
  output logic trip
);
  localparam int CW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_ld;
  guard_st_e     st_q, st_d;

  always_comb begin
    cnt_d = cnt_q;
    st_d  = st_q;
    if (!run_en) begin
      cnt_d = '0;
      st_d  = GUARD_OK;
    end else if (st_q == GUARD_TRIP) begin
      cnt_d = '0;
      if (rise) st_d = GUARD_OK;
    end else if (!dom) begin
      cnt_d = '0;
    end else if (cnt_q == LIMIT) begin
      cnt_d = '0;
      st_d  = GUARD_TRIP;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  // load only when the count moves: leaving zero or already nonzero
  assign cnt_ld = (cnt_q != '0) | (run_en & dom & (st_q == GUARD_OK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      st_q  <= GUARD_OK;
    end else begin
      if (cnt_ld) cnt_q <= cnt_d;
      st_q <= st_d;
    end
  end

  assign trip = (st_q == GUARD_TRIP);

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);

  // R3
  trip_after_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip) |-> ($past(cnt_q) == LIMIT) && $past(dom) && $past(run_en));

  // R4
  trip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trip && run_en && !rise) |=> trip);

  // R5
  trip_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trip) |-> ($past(rise) || !$past(run_en)));

  // R6
  standby_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (cnt_q == '0) && !trip);
endmodule

// File: rtl/txd_stuck_guard.sv
module txd_stuck_guard #(
  parameter int TIMEOUT_CYC = 400000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txd_in,
  input  logic active_en,
  output logic drv_txd,
  output logic fault
);
  logic txd_s;
  logic txd_rise;
  logic trip;

  tdg_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (txd_in),
    .sync_out (txd_s),
    .rise     (txd_rise)
  );

  tdg_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) timer_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_en (active_en),
    .dom    (~txd_s),
    .rise   (txd_rise),
    .trip   (trip)
  );

  assign fault   = trip;
  assign drv_txd = (active_en && !trip) ? txd_s : 1'b1;

  // R2
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_en && !trip && $past(active_en) && !$past(trip) && !txd_rise && txd_s)
      |-> $past(txd_s));
endmodule

// File: tb/txd_stuck_guard_tb_top.sv
`timescale 1ns/1ps
module txd_stuck_guard_tb_top;
  localparam int TO = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txd_in = 1'b0;
  logic active_en = 1'b1;
  logic drv_txd, fault;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 0;

  always #2.5 clk = ~clk;

  txd_stuck_guard #(.TIMEOUT_CYC(TO), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .txd_in(txd_in), .active_en(active_en),
    .drv_txd(drv_txd), .fault(fault)
  );

  task automatic chk(input string req, input logic exp_d, input logic exp_f);
    n_chk++;
    if (drv_txd !== exp_d || fault !== exp_f) begin
      n_fail++;
      $display("FAIL %s t=%0t drv_txd=%0b exp %0b fault=%0b exp %0b",
               req, $time, drv_txd, exp_d, fault, exp_f);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // R2 R3 R5: one dominant pulse of L cycles, sampled every cycle
  task automatic pulse(input int L);
    logic ef, ed;
    txd_in = 1'b0;
    for (int j = 1; j <= L + 6; j++) begin
      @(negedge clk);
      ef = (L >= TO) && (j >= TO + 2) && (j <= L + 2);
      ed = ef ? 1'b1 : !((j >= 2) && (j <= L + 1));
      chk(ef ? "R3" : (j == L + 3 ? "R5" : "R2"), ed, ef);
      if (j == L) txd_in = 1'b1;
    end
  endtask

  initial begin
    // R1: reset with txd low
    #12;
    chk("R1", 1'b1, 1'b0);
    @(negedge clk);
    txd_in = 1'b1;
    chk("R1", 1'b1, 1'b0);
    rst_n = 1'b1;
    idle(4);
    chk("R1", 1'b1, 1'b0);

    // R2 R3 R5: sweep pulse length across the limit
    for (int L = 1; L <= TO + 4; L++) pulse(L);
    // R5: full window again right after a trip
    pulse(TO - 1);
    pulse(TO);

    // R4: hold dominant for a long time
    txd_in = 1'b0;
    for (int j = 1; j <= 10 * TO; j++) begin
      @(negedge clk);
      chk("R4", (j < 2) ? 1'b1 : ((j <= TO + 1) ? 1'b0 : 1'b1), (j >= TO + 2));
    end

    // R6: standby while tripped, txd still low
    active_en = 1'b0;
    #1;
    chk("R6", 1'b1, 1'b1);
    @(negedge clk);
    chk("R6", 1'b1, 1'b0);
    for (int j = 0; j < 8; j++) begin
      txd_in = j[0];
      @(negedge clk);
      chk("R6", 1'b1, 1'b0);
    end
    txd_in = 1'b0;
    idle(4);
    chk("R6", 1'b1, 1'b0);
    active_en = 1'b1;
    #1;
    chk("R6", 1'b0, 1'b0);
    for (int j = 1; j <= TO + 3; j++) begin
      @(negedge clk);
      chk("R6", (j >= TO) ? 1'b1 : 1'b0, (j >= TO));
    end
    txd_in = 1'b1;
    idle(6);
    chk("R5", 1'b1, 1'b0);

    // R7: two sub-limit stretches split by one recessive cycle
    begin
      logic cur, p1, nv;
      cur = 1'b1;
      p1  = 1'b1;
      for (int k = 0; k < 2 * TO + 8; k++) begin
        nv = !((k < TO - 1) || ((k >= TO) && (k < 2 * TO - 1)));
        txd_in = nv;
        p1  = cur;
        cur = nv;
        @(negedge clk);
        chk("R7", p1, 1'b0);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule